// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This block takes a 32-bit IEEE-754 single-precision bit pattern and returns the 16-bit half-precision pattern nearest to it, rounding to nearest with ties going to the even value. It covers the whole input range. Zeros, infinities and NaNs keep their sign. Values too large for the half format become infinity. Small values step down gradually into half subnormals, and anything smaller still becomes a signed zero.

Each input word comes with a valid strobe and each result with its own valid flag. By default the result is registered and appears one clock after its input. When the parameter `REGISTERED` is 0, the converter is purely combinational and the flag follows the input strobe directly. The design raises no exception flags and supports only the one rounding mode. A single-precision subnormal input is far below the half range, so it always gives a signed zero.

Top module: `f32_to_f16_cvt`

## Requirements
- R1: When the input exponent field (bits 30:23) is 0xFF and the input mantissa (bits 22:0) is nonzero, the output is a quiet NaN. Bit 15 is the input sign, bits 14:10 are 0x1F, bit 9 is 1, and bits 8:0 equal input bits 21:13.
- R2: When the input exponent field is 0xFF and the mantissa is zero, the output is {sign, 0x7C00}.
- R3: When the rebased exponent (input exponent − 112) is 31 or more and the input is not NaN or infinity, the output is a signed infinity {sign, 0x7C00}. No saturation to the largest finite value takes place.
- R4: When the rebased exponent is below −10 (input exponent field below 102, which includes zero and single subnormals), the output is a signed zero {sign, 0x0000}.
- R5: When the rebased exponent lies in −10..0, the restored 24-bit significand is shifted right by (14 − rebased exponent) to form a subnormal mantissa with exponent field 0. It is then rounded to nearest, ties to even. A round-up that carries out of the mantissa gives 0x0400.
- R6: When the rebased exponent lies in 1..30, the output is {sign, rebased exponent, input bits 22:13}. One is added to the whole word when bit 12 is set and either bit 13 or any of bits 11:0 is set. The carry may therefore raise the exponent, up to infinity (for example 65520 gives 0x7C00, and 65504 gives 0x7BFF).
- R7: Output bit 15 always equals input bit 31.
- R8: With REGISTERED=1, out_valid is high exactly in the cycle after an in_valid cycle. When in_valid is low, out_bits holds its last value. Reset clears out_valid and out_bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used only when registered) |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_bits | input | 32 | Single-precision input pattern |
| out_valid | output | 1 | Result is valid |
| out_bits | output | 16 | Half-precision result pattern |

## Verification
In the default registered build, every result is due exactly one clock edge after the cycle in which its input was accepted. Results for back-to-back inputs therefore come out in a stream with one result per cycle. The bench drives each input on a falling edge and checks the result of that input on the next falling edge, while the following input is already being driven. The hold test drops in_valid and changes in_bits. It then confirms one falling edge later that out_valid has fallen and out_bits has not moved.

// File: rtl/f32_to_f16_cvt.sv
module f32_to_f16_cvt #(
  parameter bit REGISTERED = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_bits,
  output logic        out_valid,
  output logic [15:0] out_bits
);
  localparam int          IN_MW     = 23;
  localparam int          OUT_MW    = 10;
  localparam int          DROP      = IN_MW - OUT_MW;
  localparam int          BIAS_DIFF = 127 - 15;
  localparam logic [7:0]  EXP_ONES  = 8'hFF;

  logic                 sgn;
  logic [7:0]           ex;
  logic [IN_MW-1:0]     mn;
  logic signed [9:0]    hexp;
  logic [IN_MW:0]       sig;
  logic [4:0]           sh;
  logic [OUT_MW-1:0]    sub_q;
  logic [IN_MW:0]       rbit;
  logic                 sub_up;
  logic                 nrm_up;
  logic [15:0]          sub_word;
  logic [15:0]          nrm_word;
  logic [15:0]          conv;

  assign sgn  = in_bits[31];
  assign ex   = in_bits[30:23];
  assign mn   = in_bits[IN_MW-1:0];
  assign hexp = $signed({2'b00, ex}) - 10'(BIAS_DIFF);

  // subnormal path: hidden bit restored, shift 14..24
  assign sig    = {1'b1, mn};
  assign sh     = 5'(10'sd14 - hexp);
  assign sub_q  = OUT_MW'(sig >> sh);
  assign rbit   = 24'd1 << (sh - 5'd1);
  assign sub_up = (|(sig & rbit)) && (|(sig & ((rbit - 24'd1) | (rbit << 1))));
  assign sub_word = {sgn, 5'd0, sub_q} + {15'd0, sub_up};

  // normal path: increment applied to the assembled word
  assign nrm_up   = mn[DROP-1] & (mn[DROP] | (|mn[DROP-2:0]));
  assign nrm_word = {sgn, hexp[4:0], mn[IN_MW-1:DROP]} + {15'd0, nrm_up};

  always_comb begin
    if (ex == EXP_ONES)
      conv = {sgn, 5'h1F, |mn, mn[IN_MW-2:DROP]};
    else if (hexp >= 10'sd31)
      conv = {sgn, 15'h7C00};
    else if (hexp < -10'sd10)
      conv = {sgn, 15'h0000};
    else if (hexp <= 10'sd0)
      conv = sub_word;
    else
      conv = nrm_word;
  end

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          out_bits  <= 16'h0000;
        end else begin
          out_valid <= in_valid;
          if (in_valid) out_bits <= conv;
        end
      end

      p_nan_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bits[30:23] == 8'hFF && in_bits[22:0] != 23'd0)
        |=> (out_bits[14:9] == 6'h3F && out_bits[8:0] == $past(in_bits[21:13])));

      p_inf_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bits[30:0] == 31'h7F800000) |=> (out_bits[14:0] == 15'h7C00));

      p_ovf_inf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bits[30:23] >= 8'd143 && in_bits[30:23] != 8'hFF)
        |=> (out_bits[14:0] == 15'h7C00));

      p_flush_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bits[30:23] < 8'd102) |=> (out_bits[14:0] == 15'h0000));

      p_sub_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bits[30:23] >= 8'd102 && in_bits[30:23] <= 8'd112)
        |=> (out_bits[14:10] == 5'd0 || out_bits[14:0] == 15'h0400));

      p_sign_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_bits[15] == $past(in_bits[31])));

      p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

      p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_bits));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_bits  = conv;
    end
  endgenerate
endmodule

// File: tb/f32_to_f16_cvt_tb.sv
module f32_to_f16_cvt_tb;
  localparam time CLK_P = 20ns;
  localparam int  NV    = 26;

  // {input, expected, requirement number}
  localparam logic [55:0] VEC [NV] = '{
    {32'h3F800000, 16'h3C00, 8'd6},
    {32'hBF800000, 16'hBC00, 8'd7},
    {32'h00000000, 16'h0000, 8'd4},
    {32'h80000000, 16'h8000, 8'd7},
    {32'h7F800000, 16'h7C00, 8'd2},
    {32'hFF800000, 16'hFC00, 8'd2},
    {32'h7FC00000, 16'h7E00, 8'd1},
    {32'h7F800001, 16'h7E00, 8'd1},
    {32'hFFA02000, 16'hFF01, 8'd1},
    {32'h477FE000, 16'h7BFF, 8'd6},
    {32'h477FF000, 16'h7C00, 8'd6},
    {32'h47800000, 16'h7C00, 8'd3},
    {32'h7F7FFFFF, 16'h7C00, 8'd3},
    {32'h33800000, 16'h0001, 8'd5},
    {32'h33000000, 16'h0000, 8'd5},
    {32'h33000001, 16'h0001, 8'd5},
    {32'h33C00000, 16'h0002, 8'd5},
    {32'h387FC000, 16'h03FF, 8'd5},
    {32'h387FE000, 16'h0400, 8'd5},
    {32'h38800000, 16'h0400, 8'd6},
    {32'h3F801000, 16'h3C00, 8'd6},
    {32'h3F803000, 16'h3C02, 8'd6},
    {32'h3F801001, 16'h3C01, 8'd6},
    {32'h32FFFFFF, 16'h0000, 8'd4},
    {32'hB2FFFFFF, 16'h8000, 8'd4},
    {32'h00000001, 16'h0000, 8'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_bits = 32'd0;
  logic        out_valid;
  logic [15:0] out_bits;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  f32_to_f16_cvt u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .out_valid(out_valid), .out_bits(out_bits)
  );

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    logic [15:0] last;
    repeat (3) @(negedge clk);
    // R8: reset state
    check16("R8 reset out_valid", {15'd0, out_valid}, 16'd0);
    check16("R8 reset out_bits", out_bits, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check16("R8 idle out_valid", {15'd0, out_valid}, 16'd0);

    // back-to-back vector stream, result due one edge later
    for (int i = 0; i <= NV; i++) begin
      if (i > 0) begin
        check16($sformatf("R%0d vec%0d in=%h", VEC[i-1][7:0], i-1, VEC[i-1][55:24]),
                out_bits, VEC[i-1][23:8]);
        check16("R8 stream valid", {15'd0, out_valid}, 16'd1);
        check16("R7 sign", {15'd0, out_bits[15]}, {15'd0, VEC[i-1][55]});
      end
      if (i < NV) begin
        in_valid = 1'b1;
        in_bits  = VEC[i][55:24];
        @(negedge clk);
      end
    end

    // R8: hold with no valid
    last = out_bits;
    in_valid = 1'b0;
    in_bits  = 32'h3F800000;
    @(negedge clk);
    check16("R8 valid drops", {15'd0, out_valid}, 16'd0);
    check16("R8 output held", out_bits, last);
    @(negedge clk);
    check16("R8 still held", out_bits, last);

    // R8: single isolated transfer, then reset mid-run
    in_valid = 1'b1;
    in_bits  = 32'hC0000000;
    @(negedge clk);
    in_valid = 1'b0;
    check16("R6 minus two", out_bits, 16'hC000);
    check16("R8 single valid", {15'd0, out_valid}, 16'd1);
    rst_n = 1'b0;
    @(negedge clk);
    check16("R8 reset clears bits", out_bits, 16'h0000);
    check16("R8 reset clears valid", {15'd0, out_valid}, 16'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule